// File: doc/BRIEF.md
# SDRAM open-row command sequencer

This block turns single read and write requests from a local valid/ready interface into command cycles for an SDRAM device. Each request names a bank, a row and a column. The sequencer remembers which row is open in every bank. A request whose row is already open is accepted and its column command goes out at once. A request to a closed bank first opens the row. A request to a bank that holds a different row first closes that bank and then opens the new row.

Out of reset, the block programs the device's mode word before it accepts any traffic. The mode word holds the CAS latency, the burst length and the burst type. After that a free-running interval counter asks for a refresh. The refresh closes every open bank and then issues the refresh command. Minimum spacings between commands come from parameterised cycle counts, and NOP is driven while any of them is still running. For every read, a strobe returns after the CAS latency plus a fixed pipeline delay.

Top module: `sdram_row_sequencer`

## Requirements
- R1: Commands are encoded on {mem_ras_n, mem_cas_n, mem_we_n] as follows: NOP=111, ACT=011, RD=101, WR=100, PCH=010, ARF=001, LMR=000. While reset is held the pins show NOP, req_ready is 0 and rd_valid is 0.
- R2: The first command after reset is LMR on bank 0. Its mode word has the burst length code in mem_addr[2:0] (1 for 2, 2 for 4, 3 for 8), the burst type in mem_addr[3] (1 for interleaved) and the CAS latency in mem_addr[6:4], with all other bits 0. No request is accepted before it, and the next command comes no sooner than T_MRD cycles later.
- R3: A request whose bank has its row open is accepted (req_ready high) with no ACT or PCH before it. It produces RD or WR with the bank on mem_ba and the column on the low address bits, with mem_addr[10]=0.
- R4: A request to a closed bank first produces ACT, with the bank on mem_ba and the row on mem_addr. Its column command follows exactly T_RCD cycles after the ACT.
- R5: A request to a bank open on another row first produces PCH on that bank with mem_addr[10]=0. ACT for the new row follows exactly T_RP cycles later, and the column command follows that as in R4.
- R6: Two column commands are never closer than BL/2 cycles. Back-to-back hits are spaced exactly BL/2 cycles apart, with NOP in between.
- R7: During a WR command, mem_wdata equals the req_wdata of the accepted request.
- R8: rd_valid pulses for one cycle exactly CL+RD_PIPE cycles after each RD command, and once for each RD.
- R9: A refresh falls due every REF_PERIOD cycles. If any bank is open it starts with PCH with mem_addr[10]=1 (all banks). ARF follows T_RP cycles later, and the next command comes exactly T_RFC cycles after ARF. Every row counts as closed afterwards, so the next access starts with ACT.
- R10: A refresh that falls due wins over a pending request at the next command boundary. req_ready stays low, and no command for that request is issued, until the refresh has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Starting column |
| req_wdata | input | DW | First write data word |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ROW_W | Row, column or mode word |
| mem_wdata | output | DW | Write word presented with WR |
| rd_valid | output | 1 | Read data return strobe |

## Verification
A refresh falling due and a local request waiting at the same command boundary are the two functions that collide. The bench provokes this by streaming back-to-back row-hit reads across the refresh interval, so a request is always pending when the interval counter expires. It judges the result from the logged command order. A precharge-all must come first, then the refresh command T_RP later, and then, after exactly T_RFC cycles, an ACT for the stalled request rather than a column command, because refresh has closed every row.

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer #(
  parameter int NBANK      = 4,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int DW         = 16,
  parameter int CL         = 3,
  parameter int BL         = 4,
  parameter int BURST_IL   = 0,
  parameter int T_RCD      = 3,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 8,
  parameter int T_MRD      = 2,
  parameter int REF_PERIOD = 780,
  parameter int RD_PIPE    = 2,
  localparam int BA_W      = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DW-1:0]    req_wdata,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic [BA_W-1:0]  mem_ba,
  output logic [ROW_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             rd_valid
);
  localparam int T_CCD = BL / 2;
  localparam int LAT   = CL + RD_PIPE;
  localparam int GW    = $clog2(T_RFC + T_RP + T_RCD + T_MRD + BL + 1);
  localparam int REF_W = $clog2(REF_PERIOD + 1);
  localparam logic [2:0] BL_CODE = (BL == 2) ? 3'd1 : (BL == 4) ? 3'd2 : 3'd3;
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({3'(CL), 1'(BURST_IL), BL_CODE});

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD  = 3'b101,
                         C_WR  = 3'b100, C_PCH = 3'b010, C_ARF = 3'b001,
                         C_LMR = 3'b000;

  logic             init_q, ref_pend;
  logic [GW-1:0]    gap_q;
  logic [REF_W-1:0] ref_cnt;
  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];
  logic [2:0]       cmd_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LAT:0]     rd_sh;
  logic             idle, hit;

  assign idle      = init_q && (gap_q == '0);
  assign hit       = open_q[req_bank] && (row_q[req_bank] == req_row);
  assign req_ready = idle && !ref_pend && req_valid && hit;

  assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_ba    = ba_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rd_valid  = rd_sh[LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      ref_pend <= 1'b0;
      gap_q    <= '0;
      ref_cnt  <= '0;
      open_q   <= '0;
      cmd_q    <= C_NOP;
      ba_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_sh    <= '0;
      for (int i = 0; i < NBANK; i++) row_q[i] <= '0;
    end else begin
      cmd_q <= C_NOP;
      rd_sh <= {rd_sh[LAT-1:0], 1'b0};
      if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (!init_q) begin
        cmd_q  <= C_LMR;
        ba_q   <= '0;
        addr_q <= MODE_WORD;
        init_q <= 1'b1;
        gap_q  <= GW'(T_MRD - 1);
      end else if (ref_pend) begin
        if (|open_q) begin
          cmd_q      <= C_PCH;
          addr_q     <= '0;
          addr_q[10] <= 1'b1;
          open_q     <= '0;
          gap_q      <= GW'(T_RP - 1);
        end else begin
          cmd_q    <= C_ARF;
          ref_pend <= 1'b0;
          gap_q    <= GW'(T_RFC - 1);
        end
      end else if (req_valid) begin
        ba_q <= req_bank;
        if (hit) begin
          cmd_q    <= req_write ? C_WR : C_RD;
          addr_q   <= ROW_W'(req_col);
          wdata_q  <= req_wdata;
          rd_sh[0] <= !req_write;
          gap_q    <= GW'(T_CCD - 1);
        end else if (open_q[req_bank]) begin
          cmd_q            <= C_PCH;
          addr_q           <= '0;
          open_q[req_bank] <= 1'b0;
          gap_q            <= GW'(T_RP - 1);
        end else begin
          cmd_q            <= C_ACT;
          addr_q           <= req_row;
          open_q[req_bank] <= 1'b1;
          row_q[req_bank]  <= req_row;
          gap_q            <= GW'(T_RCD - 1);
        end
      end
      if (ref_cnt == REF_W'(REF_PERIOD - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> open_q[ba_q]);  // R3
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RCD > 1 && cmd_q == C_ACT) |=> cmd_q == C_NOP);  // R4
  AST_PCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RP > 1 && cmd_q == C_PCH) |=> cmd_q == C_NOP);  // R5
  AST_ARF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ARF) |-> open_q == '0);  // R9
  AST_READY_NOT_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ref_pend && req_valid && init_q));  // R10
  AST_LMR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_LMR) |=> cmd_q != C_LMR);  // R2
endmodule

// File: tb/sdram_row_sequencer_tb_top.sv
`timescale 1ns/1ps
module sdram_row_sequencer_tb_top;
  localparam int CL = 3, BL = 4, T_RCD = 3, T_RP = 3, T_RFC = 8, T_MRD = 2;
  localparam int REF = 500, PIPE = 2, LAT = CL + PIPE, T_CCD = BL / 2;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PCH = 3'b010, C_ARF = 3'b001,
                         C_LMR = 3'b000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic [15:0] wd;
    logic [1:0]  cls;   // 0 hit, 1 closed bank, 2 row conflict
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    {1'b0, 2'd0, 13'd5,    10'd8,    16'h0000, 2'd1},
    {1'b0, 2'd0, 13'd5,    10'd16,   16'h0000, 2'd0},
    {1'b1, 2'd0, 13'd5,    10'd24,   16'hA5A5, 2'd0},
    {1'b1, 2'd1, 13'd7,    10'd0,    16'h1234, 2'd1},
    {1'b0, 2'd0, 13'd9,    10'd4,    16'h0000, 2'd2},
    {1'b0, 2'd1, 13'd7,    10'd1023, 16'h0000, 2'd0},
    {1'b1, 2'd2, 13'd8191, 10'd512,  16'hFFFF, 2'd1},
    {1'b0, 2'd2, 13'd8191, 10'd3,    16'h0000, 2'd0},
    {1'b1, 2'd1, 13'd0,    10'd7,    16'h0F0F, 2'd2},
    {1'b0, 2'd3, 13'd1,    10'd9,    16'h0000, 2'd1},
    {1'b0, 2'd3, 13'd2,    10'd9,    16'h0000, 2'd2},
    {1'b0, 2'd0, 13'd9,    10'd5,    16'h0000, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, ras_n, cas_n, we_n, rd_valid;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [15:0] wdata;

  always #5 clk = ~clk;

  sdram_row_sequencer #(
    .NBANK(4), .ROW_W(13), .COL_W(10), .DW(16), .CL(CL), .BL(BL), .BURST_IL(0),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .REF_PERIOD(REF), .RD_PIPE(PIPE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .mem_ras_n(ras_n),
    .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr),
    .mem_wdata(wdata), .rd_valid(rd_valid)
  );

  int checks = 0, fails = 0, cyc = 0, nlog = 0, last_col = -100;
  bit done = 0, early_ready = 0;
  int lc [256];
  logic [2:0] lcmd [256];
  logic [1:0] lba [256];
  logic [12:0] laddr [256];
  logic [15:0] lwd [256];
  bit rv_seen [4096];
  int nrv = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (req_ready && nlog == 0) early_ready = 1;
      if ({ras_n, cas_n, we_n} != C_NOP && nlog < 256) begin
        lc[nlog] = cyc; lcmd[nlog] = {ras_n, cas_n, we_n};
        lba[nlog] = ba; laddr[nlog] = addr; lwd[nlog] = wdata;
        nlog = nlog + 1;
      end
      if (rd_valid && cyc < 4096) begin rv_seen[cyc] = 1; nrv = nrv + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_write = v.wr; req_bank = v.bank; req_row = v.row;
    req_col = v.col; req_wdata = v.wd; req_valid = 1'b1;
    #1;
    for (int t = 0; t < 200 && !req_ready; t++) begin @(negedge clk); #1; end
    chk(req_ready, "R10", "request accepted", int'(req_ready), 1);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic check_col(input int i, input vec_t v);
    chk(lcmd[i] == (v.wr ? C_WR : C_RD), "R3", "column command", lcmd[i], v.wr ? C_WR : C_RD);
    chk(lba[i] == v.bank, "R3", "column bank", lba[i], v.bank);
    chk(laddr[i] == {3'b000, v.col}, "R3", "column address", laddr[i], {3'b000, v.col});
    chk(lc[i] - last_col >= T_CCD, "R6", "column spacing", lc[i] - last_col, T_CCD);
    if (v.wr) chk(lwd[i] == v.wd, "R7", "write word", lwd[i], v.wd);
    last_col = lc[i];
  endtask

  task automatic run_vec(input vec_t v, input int idx0);
    int n, a;
    drive(v);
    n = nlog - idx0;
    chk(n == int'(v.cls) + 1, "R3", "commands for request", n, int'(v.cls) + 1);
    if (n != int'(v.cls) + 1) return;
    a = idx0;
    if (v.cls == 2) begin
      chk(lcmd[a] == C_PCH && lba[a] == v.bank && !laddr[a][10], "R5",
          "bank precharge", lcmd[a], C_PCH);
      chk(lc[a+1] - lc[a] == T_RP, "R5", "PCH to ACT", lc[a+1] - lc[a], T_RP);
      a++;
    end
    if (v.cls != 0) begin
      chk(lcmd[a] == C_ACT && lba[a] == v.bank, "R4", "activate", lcmd[a], C_ACT);
      chk(laddr[a] == v.row, "R4", "activate row", laddr[a], v.row);
      chk(lc[a+1] - lc[a] == T_RCD, "R4", "ACT to column", lc[a+1] - lc[a], T_RCD);
      a++;
    end
    check_col(a, v);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p, narf, k;
    vec_t v;
    req_write = VEC[0].wr; req_bank = VEC[0].bank; req_row = VEC[0].row;
    req_col = VEC[0].col; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n} == C_NOP, "R1", "reset command", {ras_n, cas_n, we_n}, C_NOP);
    chk(!req_ready && !rd_valid, "R1", "reset ready/strobe", {req_ready, rd_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    while (nlog < 1) begin @(negedge clk); #1; end
    chk(lcmd[0] == C_LMR && lba[0] == 0, "R2", "first command", lcmd[0], C_LMR);
    chk(laddr[0] == 13'h032, "R2", "mode word", laddr[0], 13'h032);
    run_vec(VEC[0], 1);
    chk(!early_ready, "R2", "no accept before LMR", early_ready, 0);
    chk(lc[1] - lc[0] == T_MRD, "R2", "LMR spacing", lc[1] - lc[0], T_MRD);
    for (int i = 1; i < NV; i++) begin
      run_vec(VEC[i], nlog);
      if (i == 1) chk(lc[nlog-1] - lc[nlog-2] == T_CCD, "R6", "back-to-back hits",
                      lc[nlog-1] - lc[nlog-2], T_CCD);
    end
    while (cyc < 470) @(negedge clk);
    #1;
    for (int j = 0; j < 40; j++) begin
      v = {1'b0, 2'd0, 13'd9, 10'(j), 16'h0, 2'd0};
      drive(v);
    end
    p = -1;
    for (int i = 0; i < nlog; i++) if (p < 0 && lcmd[i] == C_PCH && laddr[i][10]) p = i;
    chk(p > 0, "R9", "precharge-all seen", p, 1);
    if (p > 0) begin
      chk(lcmd[p+1] == C_ARF && lc[p+1] - lc[p] == T_RP, "R9", "ARF after PCH-all",
          lc[p+1] - lc[p], T_RP);
      chk(lcmd[p+2] == C_ACT && lc[p+2] - lc[p+1] == T_RFC, "R10", "held request reopens",
          lc[p+2] - lc[p+1], T_RFC);
      chk(lcmd[p-1] == C_RD, "R10", "stream before refresh", lcmd[p-1], C_RD);
    end
    v = {1'b1, 2'd1, 13'd0, 10'd33, 16'hBEEF, 2'd1};
    last_col = -100;
    run_vec(v, nlog);
    while (cyc < 1250) @(negedge clk);
    narf = 0;
    for (int i = 0; i < nlog; i++) if (lcmd[i] == C_ARF) narf++;
    chk(narf == 2, "R9", "refresh count", narf, 2);
    k = 0;
    for (int i = 0; i < nlog; i++)
      if (lcmd[i] == C_RD) begin
        if (!rv_seen[lc[i] + LAT]) k++;
      end
    chk(k == 0, "R8", "read strobe timing misses", k, 0);
    p = 0;
    for (int i = 0; i < nlog; i++) if (lcmd[i] == C_RD) p++;
    chk(nrv == p, "R8", "read strobe count", nrv, p);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule